// File: doc/BRIEF.md
# Dual-Order Wraparound Burst Address Sequencer

This block generates the address of each beat in a four-beat memory burst. When the load strobe is sampled high on a rising clock edge, the block captures a full starting address. After that, each clock edge on which the advance input is high moves the low two address bits to the next beat. The upper address bits stay as they were captured. After the fourth beat, the low bits wrap back to the starting offset.

A static order-select input chooses one of two beat orders:

- **Linear order (select low):** beat k sits at offset (start + k) mod 4.
- **Interleaved order (select high):** beat k sits at offset start XOR k.

A new load always restarts from the newly captured offset, even if the current burst has not finished.

The control is a two-state machine:

- **ST_IDLE** is the state after reset. The output is zero and advance is ignored.
- **ST_RUN** is entered from ST_IDLE on a load. It stays in ST_RUN on every later cycle:
  - a load restarts the burst at beat 0 with a new base;
  - an advance without a load steps the beat counter modulo 4;
  - with neither, the beat counter holds.
- Only reset returns the machine to ST_IDLE.

Top module: `burst_seq`

## Requirements
- R1: While reset is asserted and right after it, `burst_addr_o` is all zeros.
- R2: A load sampled high at a rising edge makes `burst_addr_o` equal the captured `start_addr_i` right after that edge (beat 0).
- R3: Load takes priority over advance. A load in the middle of a burst, even with advance high, restarts at beat 0 from the new address.
- R4: With `order_i` = 0, an advance edge moves the low two bits from (start + k) mod 4 to (start + k + 1) mod 4.
- R5: With `order_i` = 1, the low two bits at beat k equal start XOR k. For example, start 2 gives 2, 3, 0, 1 and start 1 gives 1, 0, 3, 2.
- R6: An edge with both load and advance low leaves `burst_addr_o` unchanged.
- R7: Four advances after a load return the low two bits to the starting offset.
- R8: Bits above the low two stay equal to the captured address for the whole burst.
- R9: Before the first load after reset, advance has no effect and the output stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture `start_addr_i` and restart the burst |
| adv_i | input | 1 | Step to the next beat |
| order_i | input | 1 | Static order select: 0 linear, 1 interleaved |
| start_addr_i | input | ADDR_W | Starting address of the burst |
| burst_addr_o | output | ADDR_W | Current beat address |

## Verification
Every result is due one rising edge after the stimulus that causes it. A load, an advance, or a hold applied before edge n shows on `burst_addr_o` just after edge n, and reset shows at once. The bench changes inputs on falling edges and samples one time unit after the following rising edge, so each check sees exactly the one edge its stimulus acted on. Both orders are swept over all four start offsets, with advance held low on some cycles. Each burst runs past the wrap, and some restarts happen mid-burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } seq_order_e;

endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_seq_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             adv_i,
    output logic             run_o,
    output logic             capture_o,
    output logic [OFS_W-1:0] beat_o
);

    seq_state_e       state_q, state_d;
    logic [OFS_W-1:0] beat_q, beat_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    // transitions and outputs
    always_comb begin
        state_d   = state_q;
        beat_d    = beat_q;
        capture_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (load_i) begin
                    state_d   = ST_RUN;
                    beat_d    = '0;
                    capture_o = 1'b1;
                end
            end
            ST_RUN: begin
                if (load_i) begin
                    beat_d    = '0;
                    capture_o = 1'b1;
                end else if (adv_i) begin
                    beat_d = beat_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign run_o  = (state_q == ST_RUN);
    assign beat_o = beat_q;

endmodule

// File: rtl/burst_ofs_map.sv
module burst_ofs_map
    import burst_seq_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0] base_i,
    input  logic [OFS_W-1:0] beat_i,
    input  logic             order_i,
    output logic [OFS_W-1:0] ofs_o
);

    logic [OFS_W-1:0] lin_ofs;
    logic [OFS_W-1:0] ilv_ofs;

    assign lin_ofs = base_i + beat_i;

    for (genvar b = 0; b < OFS_W; b++) begin : g_ilv
        assign ilv_ofs[b] = base_i[b] ^ beat_i[b];
    end

    always_comb begin
        unique case (seq_order_e'(order_i))
            ORD_LINEAR:     ofs_o = lin_ofs;
            ORD_INTERLEAVE: ofs_o = ilv_ofs;
            default:        ofs_o = lin_ofs;
        endcase
    end

endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    output logic [ADDR_W-1:0] burst_addr_o
);

    localparam int UP_W = ADDR_W - OFS_W;

    logic              seq_run;
    logic              seq_capture;
    logic [OFS_W-1:0]  seq_beat;
    logic [ADDR_W-1:0] base_q;
    logic [OFS_W-1:0]  cur_ofs;

    burst_seq_fsm #(.OFS_W(OFS_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .adv_i     (adv_i),
        .run_o     (seq_run),
        .capture_o (seq_capture),
        .beat_o    (seq_beat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (seq_capture) begin
            base_q <= start_addr_i;
        end
    end

    burst_ofs_map #(.OFS_W(OFS_W)) u_map (
        .base_i  (base_q[OFS_W-1:0]),
        .beat_i  (seq_beat),
        .order_i (order_i),
        .ofs_o   (cur_ofs)
    );

    assign burst_addr_o = {base_q[ADDR_W-1 -: UP_W], cur_ofs};

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              adv_i,
    input logic              order_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic [ADDR_W-1:0] burst_addr_o,
    input logic              run,
    input logic [OFS_W-1:0]  beat
);

    // R2
    load_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> burst_addr_o == $past(start_addr_i));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(burst_addr_o));

    // R8
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(burst_addr_o[ADDR_W-1:OFS_W]));

    // R4
    lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && adv_i && !load_i && !order_i) |=>
            burst_addr_o[OFS_W-1:0] == OFS_W'($past(burst_addr_o[OFS_W-1:0]) + 1'b1));

    // R5
    ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && adv_i && !load_i && order_i) |=>
            (burst_addr_o[OFS_W-1:0] ^ $past(burst_addr_o[OFS_W-1:0])) ==
            ($past(beat) ^ OFS_W'($past(beat) + 1'b1)));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_i) |=> burst_addr_o == '0);

endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .adv_i        (adv_i),
    .order_i      (order_i),
    .start_addr_i (start_addr_i),
    .burst_addr_o (burst_addr_o),
    .run          (seq_run),
    .beat         (seq_beat)
);

// File: tb/sim_burst_seq.sv
module sim_burst_seq;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic        adv_i = 1'b0;
    logic        order_i = 1'b0;
    logic [15:0] start_addr_i = '0;
    logic [15:0] burst_addr_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic        m_run;
    logic [15:0] m_base;
    int          m_k;

    burst_seq u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
        .order_i(order_i), .start_addr_i(start_addr_i), .burst_addr_o(burst_addr_o)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [15:0] expect_addr();
        logic [1:0] s;
        logic [1:0] o;
        if (!m_run) return 16'h0;
        s = m_base[1:0];
        o = order_i ? (s ^ 2'(m_k)) : 2'((int'(s) + m_k) % 4);
        return {m_base[15:2], o};
    endfunction

    task automatic check(string tag);
        logic [15:0] e;
        e = expect_addr();
        n_run++;
        if (burst_addr_o !== e) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, burst_addr_o, e);
        end
    endtask

    task automatic step(bit ld, bit adv, logic [15:0] a, string tag);
        @(negedge clk);
        load_i = ld; adv_i = adv; start_addr_i = a;
        @(posedge clk);
        #1;
        if (ld) begin
            m_run = 1'b1; m_base = a; m_k = 0;
        end else if (adv && m_run) begin
            m_k = (m_k + 1) % 4;
        end
        check(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; load_i = 0; adv_i = 0;
        m_run = 1'b0; m_base = '0; m_k = 0;
        #1;
        check("R1");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1");
    endtask

    initial begin
        m_run = 1'b0; m_base = '0; m_k = 0;
        #1;
        check("R1");
        do_reset();
        // R9: advance before any load
        for (int i = 0; i < 3; i++) step(0, 1, 16'hFFFF, "R9");
        for (int md = 0; md < 2; md++) begin
            order_i = md[0];
            do_reset();
            for (int s = 0; s < 4; s++) begin
                logic [15:0] a;
                a = {14'h2A5C + 14'(s * 321), 2'(s)};
                step(1, 0, a, "R2");
                for (int i = 0; i < 10; i++) begin
                    bit adv;
                    adv = (i % 3) != 1;
                    if (!adv)
                        step(0, 0, 16'h1234, "R6");
                    else if (m_k == 3)
                        step(0, 1, 16'h1234, "R7");
                    else
                        step(0, 1, 16'h1234, order_i ? "R5" : "R4");
                    if (burst_addr_o[15:2] !== a[15:2]) begin
                        n_run++; n_fail++;
                        $display("FAIL R8: got %h expected %h", burst_addr_o[15:2], a[15:2]);
                    end
                end
                // R3: reload mid-burst with advance high
                step(0, 1, 16'h0, order_i ? "R5" : "R4");
                step(1, 1, {a[15:2] ^ 14'h1111, 2'(3 - s)}, "R3");
                step(0, 1, 16'h0, order_i ? "R5" : "R4");
            end
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule